// File: doc/BRIEF.md
# Real-Mode Interrupt Entry and Return Sequencer

This block carries out the state-saving and vectoring steps that a 16-bit real-mode processor performs when control passes to an interrupt handler, and the matching restore steps when the handler returns. While idle it arbitrates among the request sources. Hardware sources are the non-maskable line, the single-step trap and the acknowledged maskable request, and these count only at an instruction boundary. Instruction-driven sources are a software interrupt with its type, the overflow-conditional interrupt and the interrupt-return request. The block captures the processor's flags, CS, IP, SS and SP in the cycle it accepts a request.

An entry writes three words below the stack pointer through a word-wide memory port. It then reads the handler offset and segment from the vector table at physical address zero, and presents the new CS, IP, flags and SP for one cycle on a done strobe. A return reads three words at and above the stack pointer and presents them the same way. The memory port has no handshake. A write completes in the cycle it is issued. Read data arrives on `mem_rdata` in the cycle after the read is issued.

The states are ST_IDLE, ST_PUSH_FL, ST_PUSH_CS, ST_PUSH_IP, ST_VEC_LO, ST_VEC_HI, ST_VEC_END, ST_POP_IP, ST_POP_CS, ST_POP_FL, ST_POP_END and ST_DONE.

- From ST_IDLE, an accepted entry request moves to ST_PUSH_FL and an accepted return moves to ST_POP_IP. With no accepted request the block stays in ST_IDLE.
- The entry path runs ST_PUSH_FL to ST_PUSH_CS to ST_PUSH_IP to ST_VEC_LO to ST_VEC_HI to ST_VEC_END to ST_DONE, one state per cycle.
- The return path runs ST_POP_IP to ST_POP_CS to ST_POP_FL to ST_POP_END to ST_DONE.
- ST_DONE always returns to ST_IDLE.

Top module: `rm_irq_seq`

## Requirements
- R1: During and right after reset the block is idle: `busy`, `done`, `mem_req` and `intr_ack` are 0.
- R2: In the three cycles after an entry is accepted, the block writes the captured flags, CS and IP, in that order. The offsets are SP-2, SP-4 and SP-6 in the stack segment. The flags word is written with TF (bit 8) and IF (bit 9) unchanged.
- R3: After the pushes, the block reads the word at physical address type×4 (handler IP) and then the word at type×4+2 (handler CS), on consecutive cycles.
- R4: Two cycles after the second vector read, `done` is high for exactly one cycle. In that cycle `new_ip` and `new_cs` carry the words read, `new_flags` is the captured flags with bits 8 and 9 cleared, and `new_sp` is SP-6.
- R5: `busy` is high from the first bus cycle of a sequence to the cycle after its last read, and low while `done` is high and while idle.
- R6: A return reads offsets SP, SP+2 and SP+4 in the stack segment as IP, CS and flags. The `done` cycle then presents these three words with `new_sp` = SP+6.
- R7: Arbitration applies a fixed priority, highest first:
  - non-maskable (type 2);
  - single-step when TF is set (type 1);
  - maskable when IF is set (type `intr_type`, with `intr_ack` high in the accepting cycle);
  - software (`sw_type`);
  - overflow-conditional (type 4);
  - return.

  The first three are considered only while `boundary` is high.
- R8: A maskable request while IF = 0 starts nothing. A non-maskable request is taken whatever IF is.
- R9: An overflow-conditional request while OF (bit 11) = 0 starts nothing.
- R10: Requests that arrive while a sequence is running, including its `done` cycle, are ignored.
- R11: Stack offsets wrap modulo 2^16 within the segment. Physical addresses are SS×16 + offset, modulo 2^20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary | input | 1 | An instruction has just completed; hardware sources may be taken |
| nmi_req | input | 1 | Non-maskable request |
| intr_req | input | 1 | Maskable request, type already acknowledged |
| intr_type | input | 8 | Type number of the maskable request |
| intr_ack | output | 1 | Maskable request accepted this cycle |
| sw_req | input | 1 | Software interrupt instruction |
| sw_type | input | 8 | Type number of the software interrupt |
| ovf_req | input | 1 | Overflow-conditional interrupt instruction |
| ret_req | input | 1 | Interrupt-return instruction |
| flags_cur | input | 16 | Current flags register |
| cs_cur | input | 16 | Current code segment |
| ip_cur | input | 16 | Return offset to save |
| ss_cur | input | 16 | Stack segment |
| sp_cur | input | 16 | Stack pointer |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 20 | Physical byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after the read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | New state valid this cycle |
| new_cs | output | 16 | Next code segment |
| new_ip | output | 16 | Next instruction offset |
| new_flags | output | 16 | Next flags value |
| new_sp | output | 16 | Next stack pointer |

## Verification
The hardest situations to reach are those where a request arrives while the block cannot take it. Examples are a non-maskable or software request held through a running entry and its `done` cycle, and several sources raised in the same boundary cycle. The bench holds these requests across the whole sequence and stacks sources in one cycle. Its reference model accepts only when its own expectation queue is empty. The stack-wrap case needs SP = 0, and also an SS that pushes the physical address past 2^20 into the vector table. Both are set up directly and then followed by a return from the wrapped frame.

// File: rtl/rm_irq_pkg.sv
package rm_irq_pkg;
    localparam int FLAG_TF = 8;
    localparam int FLAG_IF = 9;
    localparam int FLAG_OF = 11;
    localparam int TYPE_STEP = 1;
    localparam int TYPE_NMI  = 2;
    localparam int TYPE_OVF  = 4;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PUSH_FL, ST_PUSH_CS, ST_PUSH_IP,
        ST_VEC_LO, ST_VEC_HI, ST_VEC_END,
        ST_POP_IP, ST_POP_CS, ST_POP_FL, ST_POP_END,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/rm_irq_arb.sv
module rm_irq_arb
    import rm_irq_pkg::*;
#(
    parameter int TYPE_W = 8
) (
    input  logic              en,
    input  logic              boundary,
    input  logic              nmi_req,
    input  logic              intr_req,
    input  logic [TYPE_W-1:0] intr_type,
    input  logic              sw_req,
    input  logic [TYPE_W-1:0] sw_type,
    input  logic              ovf_req,
    input  logic              ret_req,
    input  logic              tf,
    input  logic              iflag,
    input  logic              of,
    output logic              take_ent,
    output logic              take_ret,
    output logic [TYPE_W-1:0] sel_type,
    output logic              intr_ack
);
    always_comb begin
        take_ent = 1'b0;
        take_ret = 1'b0;
        sel_type = '0;
        intr_ack = 1'b0;
        if (en) begin
            if (boundary && nmi_req) begin
                take_ent = 1'b1;
                sel_type = TYPE_W'(TYPE_NMI);
            end else if (boundary && tf) begin
                take_ent = 1'b1;
                sel_type = TYPE_W'(TYPE_STEP);
            end else if (boundary && intr_req && iflag) begin
                take_ent = 1'b1;
                sel_type = intr_type;
                intr_ack = 1'b1;
            end else if (sw_req) begin
                take_ent = 1'b1;
                sel_type = sw_type;
            end else if (ovf_req && of) begin
                take_ent = 1'b1;
                sel_type = TYPE_W'(TYPE_OVF);
            end else if (ret_req) begin
                take_ret = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rm_irq_bus.sv
module rm_irq_bus
    import rm_irq_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int SEG_SHIFT = 4,
    parameter int TYPE_W    = 8,
    localparam int PHYS_W   = WORD_W + SEG_SHIFT
) (
    input  seq_state_e        st,
    input  logic [TYPE_W-1:0] type_q,
    input  logic [WORD_W-1:0] ss_q,
    input  logic [WORD_W-1:0] sp_q,
    input  logic [WORD_W-1:0] fl_q,
    input  logic [WORD_W-1:0] cs_q,
    input  logic [WORD_W-1:0] ip_q,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PHYS_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata
);
    localparam int SLOT_SH = 2;
    localparam logic [WORD_W-1:0] WSTEP = WORD_W'(2);

    logic [WORD_W-1:0] seg, off, vec_base;

    assign vec_base = WORD_W'(type_q) << SLOT_SH;

    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_wdata = '0;
        seg       = ss_q;
        off       = sp_q;
        unique case (st)
            ST_PUSH_FL: begin mem_we = 1'b1; off = sp_q - WSTEP;         mem_wdata = fl_q; end
            ST_PUSH_CS: begin mem_we = 1'b1; off = sp_q - 2 * WSTEP;     mem_wdata = cs_q; end
            ST_PUSH_IP: begin mem_we = 1'b1; off = sp_q - 3 * WSTEP;     mem_wdata = ip_q; end
            ST_VEC_LO:  begin seg = '0; off = vec_base; end
            ST_VEC_HI:  begin seg = '0; off = vec_base + WSTEP; end
            ST_POP_IP:  off = sp_q;
            ST_POP_CS:  off = sp_q + WSTEP;
            ST_POP_FL:  off = sp_q + 2 * WSTEP;
            default:    mem_req = 1'b0;
        endcase
    end

    assign mem_addr = {seg, {SEG_SHIFT{1'b0}}} + PHYS_W'(off);
endmodule

// File: rtl/rm_irq_seq.sv
module rm_irq_seq
    import rm_irq_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int SEG_SHIFT = 4,
    parameter int TYPE_W    = 8,
    localparam int PHYS_W   = WORD_W + SEG_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary,
    input  logic              nmi_req,
    input  logic              intr_req,
    input  logic [TYPE_W-1:0] intr_type,
    output logic              intr_ack,
    input  logic              sw_req,
    input  logic [TYPE_W-1:0] sw_type,
    input  logic              ovf_req,
    input  logic              ret_req,
    input  logic [WORD_W-1:0] flags_cur,
    input  logic [WORD_W-1:0] cs_cur,
    input  logic [WORD_W-1:0] ip_cur,
    input  logic [WORD_W-1:0] ss_cur,
    input  logic [WORD_W-1:0] sp_cur,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PHYS_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] new_cs,
    output logic [WORD_W-1:0] new_ip,
    output logic [WORD_W-1:0] new_flags,
    output logic [WORD_W-1:0] new_sp
);
    localparam logic [WORD_W-1:0] FRAME   = WORD_W'(6);
    localparam logic [WORD_W-1:0] CLR_MSK = ~((WORD_W'(1) << FLAG_TF) | (WORD_W'(1) << FLAG_IF));

    seq_state_e        st, st_nx;
    logic              take_ent, take_ret, is_ret_q;
    logic [TYPE_W-1:0] sel_type, type_q;
    logic [WORD_W-1:0] fl_q, cs_q, ip_q, ss_q, sp_q;
    logic [WORD_W-1:0] res_ip, res_cs, res_fl;

    rm_irq_arb #(.TYPE_W(TYPE_W)) u_arb (
        .en(st == ST_IDLE), .boundary(boundary), .nmi_req(nmi_req),
        .intr_req(intr_req), .intr_type(intr_type), .sw_req(sw_req),
        .sw_type(sw_type), .ovf_req(ovf_req), .ret_req(ret_req),
        .tf(flags_cur[FLAG_TF]), .iflag(flags_cur[FLAG_IF]), .of(flags_cur[FLAG_OF]),
        .take_ent(take_ent), .take_ret(take_ret), .sel_type(sel_type),
        .intr_ack(intr_ack)
    );

    rm_irq_bus #(.WORD_W(WORD_W), .SEG_SHIFT(SEG_SHIFT), .TYPE_W(TYPE_W)) u_bus (
        .st(st), .type_q(type_q), .ss_q(ss_q), .sp_q(sp_q), .fl_q(fl_q),
        .cs_q(cs_q), .ip_q(ip_q), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:    if (take_ent) st_nx = ST_PUSH_FL;
                        else if (take_ret) st_nx = ST_POP_IP;
            ST_PUSH_FL: st_nx = ST_PUSH_CS;
            ST_PUSH_CS: st_nx = ST_PUSH_IP;
            ST_PUSH_IP: st_nx = ST_VEC_LO;
            ST_VEC_LO:  st_nx = ST_VEC_HI;
            ST_VEC_HI:  st_nx = ST_VEC_END;
            ST_VEC_END: st_nx = ST_DONE;
            ST_POP_IP:  st_nx = ST_POP_CS;
            ST_POP_CS:  st_nx = ST_POP_FL;
            ST_POP_FL:  st_nx = ST_POP_END;
            ST_POP_END: st_nx = ST_DONE;
            ST_DONE:    st_nx = ST_IDLE;
            default:    st_nx = ST_IDLE;
        endcase
    end

    // Captured context and collected results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            type_q <= '0; is_ret_q <= 1'b0;
            fl_q <= '0; cs_q <= '0; ip_q <= '0; ss_q <= '0; sp_q <= '0;
            res_ip <= '0; res_cs <= '0; res_fl <= '0;
        end else begin
            if (st == ST_IDLE && (take_ent || take_ret)) begin
                type_q   <= sel_type;
                is_ret_q <= take_ret;
                fl_q <= flags_cur; cs_q <= cs_cur; ip_q <= ip_cur;
                ss_q <= ss_cur;    sp_q <= sp_cur;
            end
            unique case (st)
                ST_VEC_HI, ST_POP_CS: res_ip <= mem_rdata;
                ST_VEC_END: begin res_cs <= mem_rdata; res_fl <= fl_q & CLR_MSK; end
                ST_POP_FL:  res_cs <= mem_rdata;
                ST_POP_END: res_fl <= mem_rdata;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy      = !(st == ST_IDLE || st == ST_DONE);
        done      = (st == ST_DONE);
        new_ip    = res_ip;
        new_cs    = res_cs;
        new_flags = res_fl;
        new_sp    = is_ret_q ? sp_q + FRAME : sp_q - FRAME;
    end

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R2
    push_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> mem_req);
    // R3
    vec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_VEC_HI) |-> (mem_addr == $past(mem_addr) + PHYS_W'(2)));
    // R7
    ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr_ack |=> (mem_req && mem_we && mem_wdata == $past(flags_cur)));
endmodule

// File: tb/rm_irq_seq_bench.sv
module rm_irq_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic boundary, nmi_req, intr_req, sw_req, ovf_req, ret_req;
    logic [7:0]  intr_type, sw_type;
    logic [15:0] flags_cur, cs_cur, ip_cur, ss_cur, sp_cur;
    logic        intr_ack, mem_req, mem_we, busy, done;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata, new_cs, new_ip, new_flags, new_sp;

    int compared = 0;
    int mismatched = 0;
    string scen = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    rm_irq_seq u_rm_irq_seq (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .nmi_req(nmi_req),
        .intr_req(intr_req), .intr_type(intr_type), .intr_ack(intr_ack),
        .sw_req(sw_req), .sw_type(sw_type), .ovf_req(ovf_req), .ret_req(ret_req),
        .flags_cur(flags_cur), .cs_cur(cs_cur), .ip_cur(ip_cur), .ss_cur(ss_cur),
        .sp_cur(sp_cur), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .new_cs(new_cs), .new_ip(new_ip), .new_flags(new_flags), .new_sp(new_sp)
    );

    // Word memory, keyed by byte address / 2
    logic [15:0] mem [int];

    function automatic int rd(int w);
        return mem.exists(w) ? int'(mem[w]) : 0;
    endfunction

    always @(posedge clk) begin
        if (mem_req && mem_we) mem[int'(mem_addr >> 1)] = mem_wdata;
        mem_rdata <= (mem_req && !mem_we) ? 16'(rd(int'(mem_addr >> 1))) : 16'h0;
    end

    // Reference model: one expected record per cycle
    typedef struct {
        bit busy, done, mreq, mwe;
        int maddr, mwdata, ncs, nip, nfl, nsp;
        string tag;
    } exp_t;
    exp_t q[$];

    function automatic int phys(int seg, int off);
        return ((seg << 4) + (off & 16'hFFFF)) & 20'hFFFFF;
    endfunction

    function automatic exp_t rec(bit b, bit d, bit r, bit w, int a, int wd, string t);
        exp_t e;
        e.busy = b; e.done = d; e.mreq = r; e.mwe = w; e.maddr = a; e.mwdata = wd;
        e.ncs = 0; e.nip = 0; e.nfl = 0; e.nsp = 0; e.tag = t;
        return e;
    endfunction

    // kind: 0 none, 1 entry, 2 return, 3 maskable entry
    function automatic int pick(output int ty);
        ty = 0;
        if (boundary && nmi_req) begin ty = 2; return 1; end
        if (boundary && flags_cur[8]) begin ty = 1; return 1; end
        if (boundary && intr_req && flags_cur[9]) begin ty = int'(intr_type); return 3; end
        if (sw_req) begin ty = int'(sw_type); return 1; end
        if (ovf_req && flags_cur[11]) begin ty = 4; return 1; end
        if (ret_req) return 2;
        return 0;
    endfunction

    task automatic push_entry(int ty);
        int sp = int'(sp_cur), ss = int'(ss_cur);
        exp_t e;
        q.push_back(rec(1, 0, 1, 1, phys(ss, sp - 2), int'(flags_cur), "R2 flags push"));
        q.push_back(rec(1, 0, 1, 1, phys(ss, sp - 4), int'(cs_cur), "R2 cs push"));
        q.push_back(rec(1, 0, 1, 1, phys(ss, sp - 6), int'(ip_cur), "R2 ip push"));
        q.push_back(rec(1, 0, 1, 0, ty * 4, 0, "R3 vec ip read"));
        q.push_back(rec(1, 0, 1, 0, ty * 4 + 2, 0, "R3 vec cs read"));
        q.push_back(rec(1, 0, 0, 0, 0, 0, "R5 busy tail"));
        e = rec(0, 1, 0, 0, 0, 0, "R4 entry done");
        e.nip = rd(ty * 2); e.ncs = rd(ty * 2 + 1);
        e.nfl = int'(flags_cur) & 16'hFCFF; e.nsp = (sp - 6) & 16'hFFFF;
        q.push_back(e);
    endtask

    task automatic push_ret();
        int sp = int'(sp_cur), ss = int'(ss_cur);
        exp_t e;
        q.push_back(rec(1, 0, 1, 0, phys(ss, sp), 0, "R6 ip pop"));
        q.push_back(rec(1, 0, 1, 0, phys(ss, sp + 2), 0, "R6 cs pop"));
        q.push_back(rec(1, 0, 1, 0, phys(ss, sp + 4), 0, "R6 flags pop"));
        q.push_back(rec(1, 0, 0, 0, 0, 0, "R5 busy tail"));
        e = rec(0, 1, 0, 0, 0, 0, "R6 return done");
        e.nip = rd(phys(ss, sp) >> 1); e.ncs = rd(phys(ss, sp + 2) >> 1);
        e.nfl = rd(phys(ss, sp + 4) >> 1); e.nsp = (sp + 6) & 16'hFFFF;
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        int k, ty;
        if (!rst_n) q.delete();
        else if (q.size() > 0) void'(q.pop_front());
        else begin
            k = pick(ty);
            if (k == 1 || k == 3) push_entry(ty);
            else if (k == 2) push_ret();
        end
    end

    task automatic chk(string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL [%s] %s: actual %h expected %h at %0t", scen, what, act, exp, $time);
        end
    endtask

    // Compare every cycle, late in the low phase
    always @(negedge clk) begin
        int k, ty;
        exp_t e;
        #(CLK_PERIOD/4);
        if (rst_n !== 1'b1) begin
            chk("R1 busy in reset", int'(busy), 0);
            chk("R1 done in reset", int'(done), 0);
            chk("R1 mem_req in reset", int'(mem_req), 0);
        end else if (q.size() == 0) begin
            k = pick(ty);
            chk("R10/R1 idle busy", int'(busy), 0);
            chk("R10/R1 idle done", int'(done), 0);
            chk("R8/R9 idle mem_req", int'(mem_req), 0);
            chk("R7 intr_ack", int'(intr_ack), (k == 3) ? 1 : 0);
        end else begin
            e = q[0];
            chk({e.tag, " busy"}, int'(busy), int'(e.busy));
            chk({e.tag, " done"}, int'(done), int'(e.done));
            chk({e.tag, " mem_req"}, int'(mem_req), int'(e.mreq));
            chk("R10 intr_ack while running", int'(intr_ack), 0);
            if (e.mreq) begin
                chk({e.tag, " mem_we"}, int'(mem_we), int'(e.mwe));
                chk({e.tag, " R11 mem_addr"}, int'(mem_addr), e.maddr);
                if (e.mwe) chk({e.tag, " mem_wdata"}, int'(mem_wdata), e.mwdata);
            end
            if (e.done) begin
                chk({e.tag, " new_ip"}, int'(new_ip), e.nip);
                chk({e.tag, " new_cs"}, int'(new_cs), e.ncs);
                chk({e.tag, " new_flags"}, int'(new_flags), e.nfl);
                chk({e.tag, " new_sp"}, int'(new_sp), e.nsp);
            end
        end
    end

    task automatic clear_reqs();
        boundary = 0; nmi_req = 0; intr_req = 0; sw_req = 0; ovf_req = 0; ret_req = 0;
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    // One-cycle request pulse
    task automatic pulse(bit b, bit n, bit i, bit s, bit o, bit r);
        @(negedge clk);
        boundary = b; nmi_req = n; intr_req = i; sw_req = s; ovf_req = o; ret_req = r;
        @(negedge clk);
        clear_reqs();
        settle();
    endtask

    task automatic ctx(int fl, int cs, int ip, int ss, int sp);
        flags_cur = 16'(fl); cs_cur = 16'(cs); ip_cur = 16'(ip); ss_cur = 16'(ss); sp_cur = 16'(sp);
    endtask

    initial begin
        for (int t = 0; t < 256; t++) begin
            mem[t * 2]     = 16'(16'h1000 + t);
            mem[t * 2 + 1] = 16'(16'hF000 ^ (t << 4));
        end
        rst_n = 1'b0;
        clear_reqs();
        intr_type = 8'h08; sw_type = 8'h21;
        ctx(16'h0002, 16'h1234, 16'h0100, 16'h3000, 16'h0800);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R3 R4 R5: software entry with IF and TF set, no boundary
        scen = "R2 R3 R4 R5 software entry";
        ctx(16'h0302, 16'h1234, 16'h0100, 16'h3000, 16'h0800);
        pulse(0, 0, 0, 1, 0, 0);

        // R6: return from the frame just built
        scen = "R6 return";
        ctx(16'h0002, 16'hF210, 16'h1021, 16'h3000, 16'h07FA);
        pulse(0, 0, 0, 0, 0, 1);

        // R7: all hardware sources at once, NMI wins
        scen = "R7 nmi over step and maskable";
        ctx(16'h0302, 16'h2000, 16'h0010, 16'h3000, 16'h0900);
        pulse(1, 1, 1, 1, 0, 0);

        // R7: step over maskable
        scen = "R7 step over maskable";
        pulse(1, 0, 1, 0, 0, 0);

        // R7: maskable with acknowledge, over software
        scen = "R7 maskable over software";
        ctx(16'h0202, 16'h2000, 16'h0010, 16'h3000, 16'h0900);
        pulse(1, 0, 1, 1, 1, 0);

        // R7: software over overflow-conditional and return
        scen = "R7 software over overflow";
        ctx(16'h0802, 16'h2000, 16'h0010, 16'h3000, 16'h0900);
        sw_type = 8'h00;
        pulse(0, 0, 0, 1, 1, 1);

        // R7: hardware sources without boundary are not taken; return is
        scen = "R7 no boundary";
        ctx(16'h0302, 16'h2000, 16'h0010, 16'h3000, 16'h08FA);
        pulse(0, 1, 1, 0, 0, 1);

        // R8: maskable with IF clear is ignored
        scen = "R8 masked";
        ctx(16'h0002, 16'h2000, 16'h0010, 16'h3000, 16'h0900);
        pulse(1, 0, 1, 0, 0, 0);

        // R8: NMI with IF clear is taken
        scen = "R8 nmi with IF clear";
        pulse(1, 1, 0, 0, 0, 0);

        // R9: overflow-conditional ignored with OF clear, taken with OF set
        scen = "R9 ovf OF clear";
        pulse(0, 0, 0, 0, 1, 0);
        scen = "R9 ovf OF set";
        ctx(16'h0802, 16'h2000, 16'h0010, 16'h3000, 16'h0900);
        pulse(0, 0, 0, 0, 1, 0);

        // R10: requests held through a running entry and its done cycle
        scen = "R10 held requests";
        ctx(16'h0202, 16'h4444, 16'h5555, 16'h3000, 16'h0A00);
        sw_type = 8'h05;
        @(negedge clk);
        sw_req = 1;
        repeat (8) begin
            @(negedge clk);
            boundary = 1; nmi_req = 1; intr_req = 1; ret_req = 1;
        end
        clear_reqs();
        settle();

        // R11: SP wraps to 0xFFFx, last table entry
        scen = "R11 sp wrap type 255";
        ctx(16'h0202, 16'h6000, 16'h0042, 16'h0000, 16'h0000);
        sw_type = 8'hFF;
        pulse(0, 0, 0, 1, 0, 0);

        // R11: physical address wraps past 1 MB into low memory
        scen = "R11 phys wrap";
        ctx(16'h0202, 16'h7777, 16'h8888, 16'hFFFF, 16'h0014);
        sw_type = 8'h03;
        pulse(0, 0, 0, 1, 0, 0);

        // R6 R11: return from the wrapped frame
        scen = "R6 R11 wrapped return";
        ctx(16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 16'h000E);
        pulse(0, 0, 0, 0, 0, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule